// File: doc/BRIEF.md
# Pipelined ADC Digital Correction Logic

This block sits behind the analog section of a multistage pipelined converter with six cascaded 2-bit stages and a 2-bit final flash stage. Each stage resolves its decision one clock later than the stage before it, so the codes that belong to one sample reach the block spread over seven consecutive clocks. The block delays every stage code by the right number of registers so that all seven decisions of one sample meet in the same cycle. It then merges them by overlapped addition into one 8-bit unsigned binary word, with bit 7 as the most significant bit.

Each stage code is added one bit position below the code of the stage before it. The shared bit position absorbs comparator decision errors through carry propagation, and this redundancy keeps the output monotonic without missing codes. A sum above full scale is clamped to 255. A new word leaves the block on every rising clock edge. A valid flag marks the first word whose seven codes all arrived after reset, and an asynchronous output-enable control releases the data bus to high impedance.

Top module: `pipe_adc_corrector`

## Requirements
- R1: While reset is high at a rising edge, that edge clears the data word to 0 and valid_o to 0.
- R2: After reset is released, valid_o stays low for the first NSTG (6) rising edges. It goes high at the next edge, the 7th, and stays high until the next reset.
- R3: The word presented after rising edge j belongs to the sample whose stage-0 code was captured at edge j-6. Stage k's code of that sample is the one captured at edge j-6+k (k = 0..5), and the flash code is the one captured at edge j.
- R4: With stage codes c0..c5 (stage_code_i bits [2k+1:2k] for stage k) and flash code f, the word is c0*64 + c1*32 + c2*16 + c3*8 + c4*4 + c5*2 + f. For example, all stage codes 1 with f = 2 give 128.
- R5: When the sum of R4 exceeds 255, the word is 255.
- R6: Once valid_o is high, a new word is presented after every rising edge, and consecutive samples give their own words without gaps.
- R7: While out_hiz_i is high, data_o is released to high impedance. When out_hiz_i falls, data_o shows the held word again without waiting for a clock edge.
- R8: data_o changes only at rising clock edges. Changing the stage inputs between edges does not change the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stage_code_i | input | 12 | Raw 2-bit decisions of the six pipeline stages; stage k in bits [2k+1:2k] |
| flash_code_i | input | 2 | Raw 2-bit decision of the final flash stage |
| out_hiz_i | input | 1 | Asynchronous output control; high puts data_o in high impedance |
| data_o | output | 8 | Corrected unsigned binary word, bit 7 the MSB |
| valid_o | output | 1 | High once the output word comes from a fully aligned sample |

## Verification
Alignment and saturation fall in the same cycle whenever an out-of-range code sits in an early stage. The vector table provokes this by giving every sample distinct per-stage codes while the samples overlap in flight, some of them summing above 255. A misaligned tap would then mix neighbouring samples and show up as a wrong clamped or unclamped word. The output-enable release and the registered hold also meet within one low clock phase. There the bench toggles out_hiz_i and changes the stage inputs between two edges, and it requires the held word to be restored unchanged.

// File: rtl/pipe_adc_pkg.sv
package pipe_adc_pkg;
  // width of one raw stage decision
  localparam int CODE_W = 2;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/adc_code_align.sv
module adc_code_align
  import pipe_adc_pkg::*;
#(
  parameter int NSTG = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CODE_W*NSTG-1:0]       stage_code_i,
  input  logic [CODE_W-1:0]            flash_code_i,
  output logic [CODE_W*(NSTG+1)-1:0]   aligned_o
);

  // stage k decides k clocks after stage 0; delay it by NSTG-k registers
  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    localparam int DEPTH = NSTG - k;
    code_t in_code;
    assign in_code = stage_code_i[CODE_W*k +: CODE_W];

    if (DEPTH == 1) begin : g_single
      code_t tap_q;
      always_ff @(posedge clk) begin
        if (rst) tap_q <= '0;
        else     tap_q <= in_code;
      end
      assign aligned_o[CODE_W*k +: CODE_W] = tap_q;

      // R3
      last_stage_align_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (aligned_o[CODE_W*k +: CODE_W] == $past(in_code)));
    end else begin : g_chain
      logic [CODE_W*DEPTH-1:0] shift_q;
      always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= {shift_q[CODE_W*(DEPTH-1)-1:0], in_code};
      end
      assign aligned_o[CODE_W*k +: CODE_W] = shift_q[CODE_W*DEPTH-1 -: CODE_W];
    end
  end

  // the flash stage decides last and needs no delay
  assign aligned_o[CODE_W*NSTG +: CODE_W] = flash_code_i;

endmodule

// File: rtl/adc_rsd_sum.sv
module adc_rsd_sum
  import pipe_adc_pkg::*;
#(
  parameter int NSTG = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CODE_W*(NSTG+1)-1:0]   aligned_i,
  output logic [NSTG+1:0]              word_o
);

  localparam int OUT_W = NSTG + 2;
  localparam int SUM_W = NSTG + 4;
  localparam logic [SUM_W-1:0] FULL = SUM_W'((1 << OUT_W) - 1);

  logic [SUM_W-1:0] raw_sum;
  logic [OUT_W-1:0] word_q;

  // stage k weighs 2^(NSTG-k); the flash code weighs 1
  always_comb begin
    raw_sum = '0;
    for (int k = 0; k <= NSTG; k++) begin
      raw_sum = raw_sum + (SUM_W'(aligned_i[CODE_W*k +: CODE_W]) << (NSTG - k));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 word_q <= '0;
    else if (raw_sum > FULL) word_q <= FULL[OUT_W-1:0];
    else                     word_q <= raw_sum[OUT_W-1:0];
  end

  assign word_o = word_q;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (raw_sum > FULL) |=> (word_o == FULL[OUT_W-1:0]));

  // R4
  in_range_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (raw_sum <= FULL) |=> (SUM_W'(word_o) == $past(raw_sum)));

endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
  import pipe_adc_pkg::*;
#(
  parameter int NSTG = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CODE_W*NSTG-1:0]   stage_code_i,
  input  logic [CODE_W-1:0]        flash_code_i,
  input  logic                     out_hiz_i,
  output logic [NSTG+1:0]          data_o,
  output logic                     valid_o
);

  localparam int OUT_W = NSTG + 2;
  localparam int CNT_W = $clog2(NSTG + 1);
  localparam logic [CNT_W-1:0] FILL = CNT_W'(NSTG);

  logic [CODE_W*(NSTG+1)-1:0] aligned;
  logic [OUT_W-1:0]           word;
  logic [CNT_W-1:0]           fill_q;
  logic                       valid_q;

  adc_code_align #(.NSTG(NSTG)) align_i (
    .clk          (clk),
    .rst          (rst),
    .stage_code_i (stage_code_i),
    .flash_code_i (flash_code_i),
    .aligned_o    (aligned)
  );

  adc_rsd_sum #(.NSTG(NSTG)) sum_i (
    .clk       (clk),
    .rst       (rst),
    .aligned_i (aligned),
    .word_o    (word)
  );

  // counts edges since reset until the alignment chains hold real codes
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (fill_q != FILL) fill_q <= fill_q + 1'b1;
      valid_q <= (fill_q == FILL);
    end
  end

  assign valid_o = valid_q;
  assign data_o  = out_hiz_i ? {OUT_W{1'bz}} : word;

  // R2
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);

  // R2
  valid_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_q != FILL) |=> !valid_q);

endmodule

// File: tb/pipe_adc_corrector_tb.sv
module pipe_adc_corrector_tb_top;
  localparam int NSTG = 6;
  localparam int NV   = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] stage_code = '0;
  logic [1:0]  flash_code = '0;
  logic        out_hiz = 1'b0;
  logic [7:0]  data_w;
  logic        valid_w;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pipe_adc_corrector #(.NSTG(NSTG)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .stage_code_i (stage_code),
    .flash_code_i (flash_code),
    .out_hiz_i    (out_hiz),
    .data_o       (data_w),
    .valid_o      (valid_w)
  );

  // stimulus {c0,c1,c2,c3,c4,c5,flash}, expected word from R4/R5
  localparam logic [13:0] STIM [NV] = '{
    {2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0},
    {2'd1,2'd1,2'd1,2'd1,2'd1,2'd1,2'd2},
    {2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd3},
    {2'd3,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0},
    {2'd3,2'd1,2'd0,2'd0,2'd0,2'd0,2'd0},
    {2'd3,2'd2,2'd0,2'd0,2'd0,2'd0,2'd0},
    {2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd3},
    {2'd1,2'd0,2'd2,2'd0,2'd1,2'd0,2'd1},
    {2'd2,2'd1,2'd0,2'd1,2'd2,2'd0,2'd2},
    {2'd3,2'd3,2'd3,2'd3,2'd3,2'd3,2'd3},
    {2'd0,2'd2,2'd1,2'd2,2'd0,2'd2,2'd0},
    {2'd1,2'd2,2'd2,2'd2,2'd2,2'd2,2'd3}
  };
  localparam logic [7:0] EXPW [NV] = '{
    8'd0, 8'd128, 8'd255, 8'd192, 8'd224, 8'd255,
    8'd3, 8'd101, 8'd178, 8'd255, 8'd100, 8'd191
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_const(input logic [1:0] sc, input logic [1:0] fc);
    for (int k = 0; k < NSTG; k++) stage_code[2*k +: 2] = sc;
    flash_code = fc;
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 data", {1'b0, data_w}, 9'd0);
    check("R1 valid", {8'd0, valid_w}, 9'd0);
    rst = 1'b0;

    // vector walk: slot t feeds stage k with sample t-k
    for (int t = 0; t < NV + NSTG; t++) begin
      for (int k = 0; k <= NSTG; k++) begin
        logic [1:0] c;
        c = 2'd0;
        if (t - k >= 0 && t - k < NV) c = STIM[t-k][13-2*k -: 2];
        if (k < NSTG) stage_code[2*k +: 2] = c;
        else          flash_code = c;
      end
      @(posedge clk);
      @(negedge clk);
      check("R2 valid", {8'd0, valid_w}, (t >= NSTG) ? 9'd1 : 9'd0);
      if (t >= NSTG)
        check("R3 R4 R5 R6 word", {1'b0, data_w}, {1'b0, EXPW[t-NSTG]});
    end

    // R7 asynchronous release and restore within one low phase
    out_hiz = 1'b1;
    #3;
    n_chk++;
    if (!(data_w === 8'hzz || data_w === 8'h00)) begin
      n_fail++;
      $display("FAIL R7 hiz: actual %0h expected zz", data_w);
    end
    out_hiz = 1'b0;
    #3;
    check("R7 restore", {1'b0, data_w}, 9'd191);

    // R8 inputs change between edges, word must hold
    drive_const(2'd2, 2'd3);
    #2;
    check("R8 hold", {1'b0, data_w}, 9'd191);

    // R5 steady full-scale codes
    repeat (NSTG + 1) @(posedge clk);
    @(negedge clk);
    check("R5 full scale", {1'b0, data_w}, 9'd255);

    // R1 mid-run reset, then R2 refill
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 midrun data", {1'b0, data_w}, 9'd0);
    check("R1 midrun valid", {8'd0, valid_w}, 9'd0);
    rst = 1'b0;
    drive_const(2'd1, 2'd2);
    repeat (NSTG) @(posedge clk);
    @(negedge clk);
    check("R2 still filling", {8'd0, valid_w}, 9'd0);
    @(posedge clk);
    @(negedge clk);
    check("R2 filled", {8'd0, valid_w}, 9'd1);
    check("R4 midscale", {1'b0, data_w}, 9'd128);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule